// File: doc/BRIEF.md
# Timed compare-match edge generator

This block drives one output pin from an absolute 64-bit time base. Software programs a 64-bit compare value and chooses an edge type. When the time base equals the armed compare value, the block produces a rising edge, a falling edge or a pin inversion on that pin. The edge appears a fixed two clock cycles after the match. A counter records every edge the block produces, and software can read it back.

Access goes through a small 32-bit register bus. A write takes effect on the clock edge that ends the cycle in which it is presented. A read is combinational from the current register state. The compare value is split into two 32-bit words. The upper word is held in a staging register. Writing the lower word commits both words at once and arms the compare, so the matcher never sees a half-written value. An armed compare fires once and then stays disarmed until the lower word is written again. The time base is expected to advance by one on every clock.

Top module: `timed_edge_gen`

## Requirements
- R1: After reset, every register reads zero, `pin_out` is 0, `pin_oe` is 1 and the event count is zero.
- R2: The control register sits at address 0x00. Bit 0 is the enable, bit 1 is the direction and bits 3:2 are the edge mode. A read returns these four bits, with bits 31:4 reading zero.
- R3: Writing address 0x14 only stages the upper compare word. Writing address 0x10 commits {staged upper word, written lower word} as the compare value and arms it. Reads of 0x10 and 0x14 return the lower and upper words of the committed value, never the staged word.
- R4: When the enable is set, the compare is armed, the edge mode is not 3 and `time_base` equals the compare value in cycle N, the pin changes at the clock edge that ends cycle N+1. The new level is therefore visible from cycle N+2.
- R5: Edge mode 0 sets the pin to 1, mode 1 clears it to 0 and mode 2 inverts it. Mode 3 produces no event and leaves the pin and the count unchanged.
- R6: A committed compare value of zero never produces an event, even when `time_base` passes zero.
- R7: An armed compare fires at most once. After a match it produces no further event, even if `time_base` returns to the same value, until address 0x10 is written again.
- R8: The event count at address 0x30 increases by exactly one with each event, on the same clock edge as the pin change.
- R9: While the enable is clear, no match is taken and the pin and the count hold their values. Clearing the enable in the match cycle also drops that in-flight event.
- R10: `pin_oe` is the inverse of the direction bit, so direction 0 drives the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the time base advances on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| time_base | input | 64 | Free-running absolute time value |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_out | output | 1 | Generated pin level |
| pin_oe | output | 1 | Pin output enable |

## Verification
A register write presented in cycle N is visible to reads from cycle N+1. A match in cycle N moves the pin from cycle N+2, and the count moves in that same cycle. The bench drives inputs just after the falling edge. It holds a behavioural model in which each match is queued with its due cycle, N+2, and the model advances once per rising edge. The pin and output-enable are compared with the model in every cycle, and every read is compared 1 ns after the inputs settle. A latency that is one cycle off, an event that fires twice, or a torn compare therefore shows up in the first affected cycle.

// File: rtl/tio_pkg.sv
package tio_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int TIME_W = 64;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CMP_LO = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CMP_HI = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h30;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_FLIP = 2'd2,
    EDGE_NONE = 2'd3
  } edge_mode_e;

  typedef struct packed {
    edge_mode_e mode;
    logic       dir;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tio_regs.sv
module tio_regs
  import tio_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int TW = TIME_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          fired,
  output ctrl_t         ctrl,
  output logic [TW-1:0] cmp,
  output logic          armed
);
  localparam int HI_W = TW - DW;

  ctrl_t           ctrl_q, ctrl_d;
  logic [HI_W-1:0] stage_q, stage_d;
  logic [TW-1:0]   cmp_q, cmp_d;
  logic            armed_q, armed_d;
  logic            ctrl_wr, hi_wr, lo_wr;

  assign ctrl_wr = wr && (addr == OFS_CTRL);
  assign hi_wr   = wr && (addr == OFS_CMP_HI);
  assign lo_wr   = wr && (addr == OFS_CMP_LO);

  always_comb begin
    ctrl_d  = ctrl_q;
    stage_d = stage_q;
    cmp_d   = cmp_q;
    armed_d = armed_q;
    if (fired) armed_d = 1'b0;
    if (ctrl_wr) ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
    if (hi_wr) stage_d = wdata[HI_W-1:0];
    if (lo_wr) begin
      cmp_d   = {stage_q, wdata};
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      stage_q <= '0;
      cmp_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      stage_q <= stage_d;
      cmp_q   <= cmp_d;
      armed_q <= armed_d;
    end
  end

  assign ctrl  = ctrl_q;
  assign cmp   = cmp_q;
  assign armed = armed_q;

  // R7
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fired |=> (!armed_q || $past(lo_wr)));

  // R3
  hi_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr && !lo_wr) |=> $stable(cmp_q));
endmodule

// File: rtl/tio_match.sv
module tio_match
  import tio_pkg::*;
#(
  parameter int TW = TIME_W,
  parameter int CW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrl_t         ctrl,
  input  logic [TW-1:0] cmp,
  input  logic          armed,
  input  logic [TW-1:0] time_base,
  output logic          fired,
  output logic          pin,
  output logic [CW-1:0] count
);
  logic          hit;
  logic          stage_q, stage_d;
  logic          pin_q, pin_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          live;

  assign live = ctrl.en && (ctrl.mode != EDGE_NONE);
  assign hit  = live && armed && (cmp != '0) && (time_base == cmp);

  always_comb begin
    stage_d = hit;
    pin_d   = pin_q;
    cnt_d   = cnt_q;
    if (stage_q && live) begin
      cnt_d = cnt_q + 1'b1;
      unique case (ctrl.mode)
        EDGE_RISE: pin_d = 1'b1;
        EDGE_FALL: pin_d = 1'b0;
        EDGE_FLIP: pin_d = ~pin_q;
        default:   pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      pin_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      stage_q <= stage_d;
      pin_q   <= pin_d;
      cnt_q   <= cnt_d;
    end
  end

  assign fired = hit;
  assign pin   = pin_q;
  assign count = cnt_q;

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1));

  // R4
  pin_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_q != $past(pin_q)) |-> $past(stage_q));

  // R9
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |=> ($stable(pin_q) && $stable(cnt_q)));

  // R6
  zero_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_q |-> ($past(cmp) != '0));
endmodule

// File: rtl/timed_edge_gen.sv
module timed_edge_gen
  import tio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_base,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pin_out,
  output logic              pin_oe
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  ctrl_t             ctrl;
  logic [TIME_W-1:0] cmp;
  logic              armed;
  logic              fired;
  logic              pin;
  logic [DATA_W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tio_regs #(.AW(ADDR_W), .DW(DATA_W), .TW(TIME_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .fired (fired),
    .ctrl  (ctrl),
    .cmp   (cmp),
    .armed (armed)
  );

  tio_match #(.TW(TIME_W), .CW(DATA_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ctrl      (ctrl),
    .cmp       (cmp),
    .armed     (armed),
    .time_base (time_base),
    .fired     (fired),
    .pin       (pin),
    .count     (count)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CTRL:   bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
      OFS_CMP_LO: bus_rdata = cmp[DATA_W-1:0];
      OFS_CMP_HI: bus_rdata = cmp[TIME_W-1:DATA_W];
      OFS_COUNT:  bus_rdata = count;
      default:    bus_rdata = '0;
    endcase
  end

  assign pin_out = pin;
  assign pin_oe  = ~ctrl.dir;

  // R10
  oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    pin_oe == !bus_rdata[1] || bus_addr != OFS_CTRL);
endmodule

// File: tb/test_timed_edge_gen.sv
module test_timed_edge_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] time_base;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        pin_out;
  logic        pin_oe;

  timed_edge_gen i_timed_edge_gen (
    .clk(clk), .rst_n(rst_n), .time_base(time_base),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [3:0]  m_ctrl = 4'h0;
  logic [31:0] m_stg  = 32'h0;
  logic [63:0] m_cmp  = 64'h0;
  bit          m_armed = 0;
  bit          m_pin   = 0;
  int unsigned m_cnt   = 0;
  longint      cyc     = 0;
  longint      pend[$];
  logic [63:0] tb_next = 64'h0;
  string       cur_tag = "R4";

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00:   return {28'h0, m_ctrl};
      8'h10:   return m_cmp[31:0];
      8'h14:   return m_cmp[63:32];
      8'h30:   return m_cnt;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic model_step(input bit w, input logic [7:0] a, input logic [31:0] d,
                            input logic [63:0] tb);
    bit en = m_ctrl[0];
    logic [1:0] mode = m_ctrl[3:2];
    if (pend.size() > 0 && pend[0] == cyc + 1) begin
      void'(pend.pop_front());
      if (en && mode != 2'd3) begin
        if (mode == 2'd0) m_pin = 1;
        else if (mode == 2'd1) m_pin = 0;
        else m_pin = !m_pin;
        m_cnt++;
      end
    end
    if (en && mode != 2'd3 && m_armed && m_cmp != 64'h0 && tb == m_cmp) begin
      pend.push_back(cyc + 2);
      m_armed = 0;
    end
    if (w) begin
      if (a == 8'h00) m_ctrl = d[3:0];
      else if (a == 8'h14) m_stg = d;
      else if (a == 8'h10) begin m_cmp = {m_stg, d}; m_armed = 1; end
    end
    cyc++;
  endtask

  task automatic step(input bit w, input logic [7:0] a, input logic [31:0] d,
                      input string rtag);
    @(negedge clk);
    chk(cur_tag, {63'h0, pin_out}, {63'h0, m_pin});
    chk("R10", {63'h0, pin_oe}, {63'h0, !m_ctrl[1]});
    time_base = tb_next;
    bus_wr    = w;
    bus_addr  = a;
    bus_wdata = d;
    #1;
    if (!w) chk(rtag, {32'h0, bus_rdata}, {32'h0, m_read(a)});
    model_step(w, a, d, tb_next);
    tb_next = tb_next + 64'd1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h30, 32'h0, "R8");
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1, a, d, "R2");
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(0, a, 32'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; time_base = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1: reset values at the ports and in every register
    cur_tag = "R1";
    rd(8'h00, "R1"); rd(8'h10, "R1"); rd(8'h14, "R1"); rd(8'h30, "R1");
    rd(8'h00, "R1");

    // R2: control fields and read-back width
    cur_tag = "R4";
    wr(8'h00, 32'hFFFF_FFF9);
    rd(8'h00, "R2");

    // R4: inversion at two-cycle latency
    wr(8'h14, 32'h0);
    wr(8'h10, tb_next[31:0] + 32'd6);
    idle(10);
    rd(8'h30, "R8");

    // R5: rising, falling and no-event modes
    cur_tag = "R5";
    wr(8'h00, 32'h1);
    wr(8'h10, tb_next[31:0] + 32'd4);
    idle(8);
    wr(8'h00, 32'h5);
    wr(8'h10, tb_next[31:0] + 32'd4);
    idle(8);
    wr(8'h00, 32'hD);
    wr(8'h10, tb_next[31:0] + 32'd4);
    idle(8);
    rd(8'h30, "R5");

    // R6: zero compare never fires across wrap
    cur_tag = "R6";
    wr(8'h00, 32'h9);
    wr(8'h14, 32'h0);
    wr(8'h10, 32'h0);
    tb_next = 64'hFFFF_FFFF_FFFF_FFFC;
    idle(10);
    rd(8'h30, "R6");

    // R7: fire once, re-arm via lower word
    cur_tag = "R7";
    wr(8'h10, tb_next[31:0] + 32'd5);
    idle(8);
    tb_next = tb_next - 64'd9;
    idle(10);
    rd(8'h30, "R7");
    wr(8'h10, tb_next[31:0] + 32'd4);
    idle(8);
    rd(8'h30, "R7");

    // R3: staging does not tear the armed value
    cur_tag = "R3";
    wr(8'h10, tb_next[31:0] + 32'd6);
    wr(8'h14, 32'h5);
    rd(8'h14, "R3");
    idle(8);
    rd(8'h30, "R3");
    tb_next = 64'h0000_0001_0000_0000 - 64'd12;
    wr(8'h14, 32'h1);
    wr(8'h10, 32'h0);
    rd(8'h14, "R3");
    rd(8'h10, "R3");
    idle(14);
    rd(8'h30, "R3");

    // R9: disable in the match cycle drops the event
    cur_tag = "R9";
    begin
      logic [31:0] t = tb_next[31:0];
      wr(8'h14, tb_next[63:32]);
      wr(8'h10, t + 32'd4);
      idle(2);
      wr(8'h00, 32'h8);
    end
    idle(6);
    rd(8'h30, "R9");
    wr(8'h10, tb_next[31:0] + 32'd3);
    idle(8);
    rd(8'h30, "R9");

    // R10: direction bit drops output enable, events still counted
    cur_tag = "R10";
    wr(8'h00, 32'hB);
    wr(8'h10, tb_next[31:0] + 32'd3);
    idle(8);
    rd(8'h30, "R10");
    wr(8'h00, 32'h9);
    idle(3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule